// File: doc/BRIEF.md
# Instruction Field Decoder with Immediate Builder

This block is a purely combinational front-end stage for a 32-bit load/store processor datapath. It looks at one fetched instruction word and works out its encoding class from the six-bit opcode at the top of the word. The three classes are register-register, immediate and jump. It then separates the word into the pieces that the rest of the pipeline consumes:
- the two source register indices;
- the destination register index and a register-write enable;
- the shift amount and the function code;
- a 32-bit immediate operand, already widened;
- the 26-bit jump index.

Fields that carry no meaning for the detected class are driven to zero. A seven-bit mask tells downstream logic which fields are live. The immediate is widened in one of three ways, chosen by opcode:
- sign extension, the default for every immediate-class opcode, including the unsigned arithmetic and compare variants;
- zero extension for the three bitwise-logic opcodes;
- placement in the upper half of the word for the load-upper opcode, which is also flagged on its own output.

The block has no clock and no state. It is meant to sit between the instruction register and the register-file read ports. Its outputs are settled one combinational delay after the instruction word changes.

Top module: `insn_field_decoder`

## Requirements
- R1: The opcode is bits 31:26. Opcode 0 gives class code 0 (register-register). Opcodes 2 and 3 give class code 2 (jump). Every other opcode (1, 4 to 63) gives class code 1 (immediate). Class code 3 never appears.
- R2: In class 0, the field outputs are taken from the word as follows:
  - rs from bits 25:21;
  - rt from bits 20:16;
  - rd from bits 15:11;
  - shamt from bits 10:6;
  - funct from bits 5:0.

  The destination output equals rd. The immediate and jump index outputs are 0.
- R3: In class 1, rs comes from bits 25:21 and rt from bits 20:16. The rd, shamt, funct and jump index outputs are 0. The destination output equals rt.
- R4: In class 1, for every opcode other than 12, 13, 14 and 15, the immediate output is bits 15:0 sign-extended to 32 bits. This includes add-immediate-unsigned (9) and set-less-than-immediate-unsigned (11).
- R5: For opcodes 12, 13 and 14 (bitwise and, or, xor with immediate), the immediate output is bits 15:0 zero-extended to 32 bits.
- R6: For opcode 15 (load upper), the immediate output carries bits 15:0 of the word in its bits 31:16, and its bits 15:0 are 0. The load-upper flag is 1 for opcode 15 and 0 for every other opcode.
- R7: In class 2, the jump index output equals bits 25:0. The rs, rt, rd, shamt, funct, immediate and destination outputs are all 0, and the write enable is 0.
- R8: The field mask uses one bit per field: bit 0 rs, bit 1 rt, bit 2 rd, bit 3 shamt, bit 4 funct, bit 5 immediate, bit 6 jump index. Its value is 0x1F in class 0, 0x23 in class 1 and 0x40 in class 2.
- R9: The write enable is 1 exactly when the class is 0 or 1 and the destination index is not 0. A destination of register 0 never produces a write.
- R10: The all-zero word decodes as class 0 with every field 0, mask 0x1F and write enable 0. This is the no-operation encoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 32 | Instruction word to decode |
| fmt_o | output | 2 | Encoding class: 0 register-register, 1 immediate, 2 jump |
| fld_mask_o | output | 7 | Live-field mask (bit 0 rs … bit 6 jump index) |
| rs_o | output | 5 | First source register index |
| rt_o | output | 5 | Second source / immediate-class target index |
| rd_o | output | 5 | Register-register destination field |
| dest_o | output | 5 | Register index to be written |
| wr_en_o | output | 1 | Register write enable (0 when dest_o is 0) |
| shamt_o | output | 5 | Shift amount |
| funct_o | output | 6 | Function code |
| imm_o | output | 32 | Widened immediate operand |
| jidx_o | output | 26 | Jump target index |
| is_lui_o | output | 1 | Load-upper opcode detected |

## Verification
The bench targets the class boundaries: opcode 1 and opcode 63 must land in the immediate class and opcodes 2 and 3 in the jump class, so a decoder that tested only the low opcode bit or compared against a range would misfile one of them. For the immediates, an unsigned-add word with bit 15 set must come out sign-extended. The logic-immediate words with bit 15 set must come out zero-extended, and a design that keyed extension on the arithmetic opcodes would flip one of these. Destination steering is checked on words whose low half decodes to a nonzero rd, to catch a decoder that always picks rd, and on words that target register 0, to catch a write enable that ignores the zero register. Jump words with all ones in the low 26 bits expose a design that leaks the raw fields through instead of zeroing them.

// File: rtl/ifd_pkg.sv
// Package: shared widths, class codes, mask bits and opcode values for the
// instruction field decoder. Assumes a 32-bit fixed-width instruction word.
package ifd_pkg;

    localparam int XLEN    = 32;
    localparam int OPC_W   = 6;
    localparam int REG_W   = 5;
    localparam int SHAMT_W = 5;
    localparam int FUNCT_W = 6;
    localparam int IMM_W   = 16;
    localparam int JIDX_W  = XLEN - OPC_W;
    localparam int MASK_W  = 7;

    typedef enum logic [1:0] {
        FMT_REG  = 2'd0,
        FMT_IMM  = 2'd1,
        FMT_JUMP = 2'd2
    } fmt_e;

    // Live-field mask bit positions
    localparam int MB_RS    = 0;
    localparam int MB_RT    = 1;
    localparam int MB_RD    = 2;
    localparam int MB_SHAMT = 3;
    localparam int MB_FUNCT = 4;
    localparam int MB_IMM   = 5;
    localparam int MB_JIDX  = 6;

    // Opcodes with special meaning to the decoder
    localparam logic [OPC_W-1:0] OP_SPECIAL = 6'd0;
    localparam logic [OPC_W-1:0] OP_JMP     = 6'd2;
    localparam logic [OPC_W-1:0] OP_JMPLNK  = 6'd3;
    localparam logic [OPC_W-1:0] OP_ANDI    = 6'd12;
    localparam logic [OPC_W-1:0] OP_ORI     = 6'd13;
    localparam logic [OPC_W-1:0] OP_XORI    = 6'd14;
    localparam logic [OPC_W-1:0] OP_LDUP    = 6'd15;

endpackage

// File: rtl/ifd_format_sel.sv
// Module: ifd_format_sel
// Classifies an opcode into one of three encoding classes and produces the
// matching live-field mask. Assumes the opcode alone picks the class.
module ifd_format_sel
    import ifd_pkg::*;
#(
    parameter int OPW = OPC_W,
    parameter int MW  = MASK_W
) (
    input  logic [OPW-1:0] opcode_i,
    output fmt_e           fmt_o,
    output logic [MW-1:0]  mask_o
);

    // Decide the encoding class from the opcode value
    always_comb begin
        if (opcode_i == OP_SPECIAL[OPW-1:0]) begin
            fmt_o = FMT_REG;
        end else if (opcode_i == OP_JMP[OPW-1:0] ||
                     opcode_i == OP_JMPLNK[OPW-1:0]) begin
            fmt_o = FMT_JUMP;
        end else begin
            fmt_o = FMT_IMM;
        end
    end

    // Build the live-field mask for the chosen class
    always_comb begin
        mask_o = '0;
        unique case (fmt_o)
            FMT_REG: begin
                mask_o[MB_RS]    = 1'b1;
                mask_o[MB_RT]    = 1'b1;
                mask_o[MB_RD]    = 1'b1;
                mask_o[MB_SHAMT] = 1'b1;
                mask_o[MB_FUNCT] = 1'b1;
            end
            FMT_IMM: begin
                mask_o[MB_RS]  = 1'b1;
                mask_o[MB_RT]  = 1'b1;
                mask_o[MB_IMM] = 1'b1;
            end
            default: begin
                mask_o[MB_JIDX] = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ifd_field_split.sv
// Module: ifd_field_split
// Slices register, shift, function and jump fields out of the word, zeroing
// those not live for the class, and steers the destination between rd and rt.
// Assumes the fixed bit layout described in the brief (R2, R3, R7).
module ifd_field_split
    import ifd_pkg::*;
#(
    parameter int W   = XLEN,
    parameter int RW  = REG_W,
    parameter int SW  = SHAMT_W,
    parameter int FW  = FUNCT_W,
    parameter int JW  = JIDX_W
) (
    input  logic [W-1:0]  insn_i,
    input  fmt_e          fmt_i,
    output logic [RW-1:0] rs_o,
    output logic [RW-1:0] rt_o,
    output logic [RW-1:0] rd_o,
    output logic [SW-1:0] shamt_o,
    output logic [FW-1:0] funct_o,
    output logic [JW-1:0] jidx_o,
    output logic [RW-1:0] dest_o,
    output logic          wr_en_o
);

    localparam int RS_LSB    = W - OPC_W - RW;
    localparam int RT_LSB    = RS_LSB - RW;
    localparam int RD_LSB    = RT_LSB - RW;
    localparam int SHAMT_LSB = RD_LSB - SW;

    logic [RW-1:0] rs_raw, rt_raw, rd_raw;
    logic [SW-1:0] shamt_raw;
    logic [FW-1:0] funct_raw;
    logic [JW-1:0] jidx_raw;

    // Raw bit slices at their fixed positions
    assign rs_raw    = insn_i[RS_LSB    +: RW];
    assign rt_raw    = insn_i[RT_LSB    +: RW];
    assign rd_raw    = insn_i[RD_LSB    +: RW];
    assign shamt_raw = insn_i[SHAMT_LSB +: SW];
    assign funct_raw = insn_i[0         +: FW];
    assign jidx_raw  = insn_i[0         +: JW];

    // Gate each field by the class that gives it meaning
    always_comb begin
        rs_o    = '0;
        rt_o    = '0;
        rd_o    = '0;
        shamt_o = '0;
        funct_o = '0;
        jidx_o  = '0;
        unique case (fmt_i)
            FMT_REG: begin
                rs_o    = rs_raw;
                rt_o    = rt_raw;
                rd_o    = rd_raw;
                shamt_o = shamt_raw;
                funct_o = funct_raw;
            end
            FMT_IMM: begin
                rs_o = rs_raw;
                rt_o = rt_raw;
            end
            default: begin
                jidx_o = jidx_raw;
            end
        endcase
    end

    // Steer the written register: rd for register class, rt for immediate class
    always_comb begin
        unique case (fmt_i)
            FMT_REG: dest_o = rd_raw;
            FMT_IMM: dest_o = rt_raw;
            default: dest_o = '0;
        endcase
    end

    // Suppress writes that would target the hard-wired zero register
    assign wr_en_o = (fmt_i != FMT_JUMP) && (dest_o != '0);

endmodule

// File: rtl/ifd_imm_gen.sv
// Module: ifd_imm_gen
// Widens the 16-bit immediate field to the datapath width: sign extension by
// default, zero extension for the bitwise-logic opcodes, upper-half placement
// for load-upper. Assumes the caller gates the result by class.
module ifd_imm_gen
    import ifd_pkg::*;
#(
    parameter int W   = XLEN,
    parameter int IW  = IMM_W,
    parameter int OPW = OPC_W
) (
    input  logic [OPW-1:0] opcode_i,
    input  logic [IW-1:0]  imm_raw_i,
    input  logic           imm_live_i,
    output logic [W-1:0]   imm_o,
    output logic           is_lui_o
);

    localparam int PADW = W - IW;

    typedef enum logic [1:0] {
        EXT_SIGN  = 2'd0,
        EXT_ZERO  = 2'd1,
        EXT_UPPER = 2'd2
    } ext_e;

    ext_e         ext_sel;
    logic [W-1:0] sext_v;
    logic [W-1:0] zext_v;
    logic [W-1:0] upper_v;

    // Pick the widening rule from the opcode
    always_comb begin
        if (opcode_i == OP_LDUP[OPW-1:0]) begin
            ext_sel = EXT_UPPER;
        end else if (opcode_i == OP_ANDI[OPW-1:0] ||
                     opcode_i == OP_ORI[OPW-1:0]  ||
                     opcode_i == OP_XORI[OPW-1:0]) begin
            ext_sel = EXT_ZERO;
        end else begin
            ext_sel = EXT_SIGN;
        end
    end

    // Three candidate widened values; the upper-half form needs W >= 2*IW
    generate
        if (PADW >= IW) begin : g_upper_fits
            assign upper_v = {imm_raw_i, {(W-IW){1'b0}}} ;
        end else begin : g_upper_trunc
            assign upper_v = {imm_raw_i[IW-1 -: PADW], {IW{1'b0}}};
        end
    endgenerate
    assign sext_v = {{PADW{imm_raw_i[IW-1]}}, imm_raw_i};
    assign zext_v = {{PADW{1'b0}}, imm_raw_i};

    // Select the widened value, or zero when the class has no immediate
    always_comb begin
        if (!imm_live_i) begin
            imm_o = '0;
        end else begin
            unique case (ext_sel)
                EXT_UPPER: imm_o = upper_v;
                EXT_ZERO:  imm_o = zext_v;
                default:   imm_o = sext_v;
            endcase
        end
    end

    // Load-upper flag straight from the opcode
    assign is_lui_o = (opcode_i == OP_LDUP[OPW-1:0]);

endmodule

// File: rtl/insn_field_decoder.sv
// Module: insn_field_decoder (top)
// Combinational decoder of one instruction word into class, live-field mask,
// register indices, write enable, shift amount, function code, immediate and
// jump index. Assumes a 32-bit word with the opcode in the top six bits.
module insn_field_decoder
    import ifd_pkg::*;
(
    input  logic [31:0] insn_i,
    output logic [1:0]  fmt_o,
    output logic [6:0]  fld_mask_o,
    output logic [4:0]  rs_o,
    output logic [4:0]  rt_o,
    output logic [4:0]  rd_o,
    output logic [4:0]  dest_o,
    output logic        wr_en_o,
    output logic [4:0]  shamt_o,
    output logic [5:0]  funct_o,
    output logic [31:0] imm_o,
    output logic [25:0] jidx_o,
    output logic        is_lui_o
);

    logic [OPC_W-1:0] opcode;
    fmt_e             fmt;
    logic [MASK_W-1:0] mask;

    // Opcode sits at the top of the word
    assign opcode = insn_i[XLEN-1 -: OPC_W];

    ifd_format_sel #(
        .OPW (OPC_W),
        .MW  (MASK_W)
    ) u_fmt (
        .opcode_i (opcode),
        .fmt_o    (fmt),
        .mask_o   (mask)
    );

    ifd_field_split #(
        .W  (XLEN),
        .RW (REG_W),
        .SW (SHAMT_W),
        .FW (FUNCT_W),
        .JW (JIDX_W)
    ) u_split (
        .insn_i  (insn_i),
        .fmt_i   (fmt),
        .rs_o    (rs_o),
        .rt_o    (rt_o),
        .rd_o    (rd_o),
        .shamt_o (shamt_o),
        .funct_o (funct_o),
        .jidx_o  (jidx_o),
        .dest_o  (dest_o),
        .wr_en_o (wr_en_o)
    );

    ifd_imm_gen #(
        .W   (XLEN),
        .IW  (IMM_W),
        .OPW (OPC_W)
    ) u_imm (
        .opcode_i   (opcode),
        .imm_raw_i  (insn_i[IMM_W-1:0]),
        .imm_live_i (mask[MB_IMM]),
        .imm_o      (imm_o),
        .is_lui_o   (is_lui_o)
    );

    // Export class and mask as plain vectors
    assign fmt_o      = fmt;
    assign fld_mask_o = mask;

endmodule

// File: rtl/ifd_checker.sv
// Module: ifd_checker
// Consistency checks across the decoder outputs, bound to the top. Assumes
// a combinational design, so checks are immediate and skip unknown inputs.
module ifd_checker (
    input logic [31:0] insn_i,
    input logic [1:0]  fmt_o,
    input logic [6:0]  fld_mask_o,
    input logic [4:0]  rs_o,
    input logic [4:0]  rt_o,
    input logic [4:0]  rd_o,
    input logic [4:0]  dest_o,
    input logic        wr_en_o,
    input logic [4:0]  shamt_o,
    input logic [5:0]  funct_o,
    input logic [31:0] imm_o,
    input logic [25:0] jidx_o,
    input logic        is_lui_o
);

    // Output-to-output relations, checked whenever the word is known
    always_comb begin
        if (!$isunknown(insn_i)) begin
            p_fmt_legal_r1: assert (fmt_o != 2'd3);
            p_mask_onehot_class_r8: assert (
                (fmt_o == 2'd0 && fld_mask_o == 7'h1F) ||
                (fmt_o == 2'd1 && fld_mask_o == 7'h23) ||
                (fmt_o == 2'd2 && fld_mask_o == 7'h40));
            p_jump_quiet_r7: assert (fmt_o != 2'd2 ||
                (rs_o == '0 && rt_o == '0 && rd_o == '0 && shamt_o == '0 &&
                 funct_o == '0 && imm_o == '0 && !wr_en_o));
            p_lui_low_clear_r6: assert (!is_lui_o || imm_o[15:0] == 16'h0);
            p_zero_dest_no_write_r9: assert (dest_o != 5'd0 || !wr_en_o);
            p_imm_dest_is_rt_r3: assert (fmt_o != 2'd1 || dest_o == rt_o);
            p_reg_dest_is_rd_r2: assert (fmt_o != 2'd0 ||
                (dest_o == rd_o && imm_o == '0 && jidx_o == '0));
        end
    end

endmodule

bind insn_field_decoder ifd_checker u_ifd_checker (.*);

// File: tb/insn_field_decoder_bench.sv
`timescale 1ns/1ps
module insn_field_decoder_bench;

    typedef struct packed {
        logic [31:0] insn;
        logic [1:0]  fmt;
        logic [4:0]  dest;
        logic        wr;
        logic [31:0] imm;
        logic [25:0] jidx;
        logic        lui;
        logic [6:0]  mask;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VEC [NVEC] = '{
        // R2 add r8,r9,r10
        '{32'h012A4020, 2'd0, 5'd8,  1'b1, 32'h00000000, 26'h0,       1'b0, 7'h1F},
        // R4 add-immediate, negative
        '{32'h22D5FFCE, 2'd1, 5'd21, 1'b1, 32'hFFFFFFCE, 26'h0,       1'b0, 7'h23},
        // R4 unsigned add-immediate still sign-extended
        '{32'h24058000, 2'd1, 5'd5,  1'b1, 32'hFFFF8000, 26'h0,       1'b0, 7'h23},
        // R4 unsigned set-less-than-immediate
        '{32'h2C22FFFF, 2'd1, 5'd2,  1'b1, 32'hFFFFFFFF, 26'h0,       1'b0, 7'h23},
        // R5 or-immediate zero-extended
        '{32'h3421CDCD, 2'd1, 5'd1,  1'b1, 32'h0000CDCD, 26'h0,       1'b0, 7'h23},
        // R5 and-immediate, bit 15 set
        '{32'h30038001, 2'd1, 5'd3,  1'b1, 32'h00008001, 26'h0,       1'b0, 7'h23},
        // R5 R9 xor-immediate to register 0
        '{32'h3880FFFF, 2'd1, 5'd0,  1'b0, 32'h0000FFFF, 26'h0,       1'b0, 7'h23},
        // R6 load upper
        '{32'h3C01ABAB, 2'd1, 5'd1,  1'b1, 32'hABAB0000, 26'h0,       1'b1, 7'h23},
        // R7 jump opcode 2
        '{32'h08100001, 2'd2, 5'd0,  1'b0, 32'h00000000, 26'h0100001, 1'b0, 7'h40},
        // R7 jump opcode 3, all-ones index
        '{32'h0FFFFFFF, 2'd2, 5'd0,  1'b0, 32'h00000000, 26'h3FFFFFF, 1'b0, 7'h40},
        // R10 all-zero word
        '{32'h00000000, 2'd0, 5'd0,  1'b0, 32'h00000000, 26'h0,       1'b0, 7'h1F},
        // R4 R9 branch to register-0 compare
        '{32'h11000003, 2'd1, 5'd0,  1'b0, 32'h00000003, 26'h0,       1'b0, 7'h23},
        // R4 load word negative offset
        '{32'h8FA8FFFC, 2'd1, 5'd8,  1'b1, 32'hFFFFFFFC, 26'h0,       1'b0, 7'h23},
        // R1 opcode 1 is immediate class
        '{32'h04000000, 2'd1, 5'd0,  1'b0, 32'h00000000, 26'h0,       1'b0, 7'h23},
        // R1 opcode 63 is immediate class
        '{32'hFC1F7FFF, 2'd1, 5'd31, 1'b1, 32'h00007FFF, 26'h0,       1'b0, 7'h23},
        // R2 shift with shamt 4
        '{32'h00094100, 2'd0, 5'd8,  1'b1, 32'h00000000, 26'h0,       1'b0, 7'h1F},
        // R9 register class to rd 0
        '{32'h012A0020, 2'd0, 5'd0,  1'b0, 32'h00000000, 26'h0,       1'b0, 7'h1F}
    };

    logic        clk;
    logic        rst_n;
    logic [31:0] insn;
    logic [1:0]  fmt;
    logic [6:0]  mask;
    logic [4:0]  rs, rt, rd, dest, shamt;
    logic        wr_en, is_lui;
    logic [5:0]  funct;
    logic [31:0] imm;
    logic [25:0] jidx;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    insn_field_decoder u_insn_field_decoder (
        .insn_i     (insn),
        .fmt_o      (fmt),
        .fld_mask_o (mask),
        .rs_o       (rs),
        .rt_o       (rt),
        .rd_o       (rd),
        .dest_o     (dest),
        .wr_en_o    (wr_en),
        .shamt_o    (shamt),
        .funct_o    (funct),
        .imm_o      (imm),
        .jidx_o     (jidx),
        .is_lui_o   (is_lui)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w);
        @(posedge clk);
        insn = w;
        @(negedge clk);
    endtask

    initial begin
        insn  = 32'h0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R10 state after reset: zero word applied
        @(negedge clk);
        chk("R10", "fmt", {30'b0, fmt}, 32'd0);
        chk("R10", "wr_en", {31'b0, wr_en}, 32'd0);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i].insn);
            chk("R1",  "fmt",  {30'b0, fmt},    {30'b0, VEC[i].fmt});
            chk("R2R3","dest", {27'b0, dest},   {27'b0, VEC[i].dest});
            chk("R9",  "wr_en",{31'b0, wr_en},  {31'b0, VEC[i].wr});
            chk("R4R5","imm",  imm,             VEC[i].imm);
            chk("R7",  "jidx", {6'b0, jidx},    {6'b0, VEC[i].jidx});
            chk("R6",  "lui",  {31'b0, is_lui}, {31'b0, VEC[i].lui});
            chk("R8",  "mask", {25'b0, mask},   {25'b0, VEC[i].mask});
        end

        // R2 field slices of add r8,r9,r10
        apply(32'h012A4020);
        chk("R2", "rs",    {27'b0, rs},    32'd9);
        chk("R2", "rt",    {27'b0, rt},    32'd10);
        chk("R2", "rd",    {27'b0, rd},    32'd8);
        chk("R2", "funct", {26'b0, funct}, 32'd32);
        chk("R2", "shamt", {27'b0, shamt}, 32'd0);

        // R2 shift amount field
        apply(32'h00094100);
        chk("R2", "shamt", {27'b0, shamt}, 32'd4);

        // R3 immediate class zeroes rd/shamt/funct despite nonzero low bits
        apply(32'h22D5FFCE);
        chk("R3", "rs",    {27'b0, rs},    32'd22);
        chk("R3", "rt",    {27'b0, rt},    32'd21);
        chk("R3", "rd",    {27'b0, rd},    32'd0);
        chk("R3", "shamt", {27'b0, shamt}, 32'd0);
        chk("R3", "funct", {26'b0, funct}, 32'd0);

        // R7 jump with all-ones low bits keeps register fields zero
        apply(32'h0FFFFFFF);
        chk("R7", "rs",    {27'b0, rs},    32'd0);
        chk("R7", "rt",    {27'b0, rt},    32'd0);
        chk("R7", "rd",    {27'b0, rd},    32'd0);
        chk("R7", "funct", {26'b0, funct}, 32'd0);

        // R10 all-zero word fields
        apply(32'h00000000);
        chk("R10", "rs",   {27'b0, rs},   32'd0);
        chk("R10", "dest", {27'b0, dest}, 32'd0);
        chk("R10", "mask", {25'b0, mask}, 32'h1F);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule